// File: doc/BRIEF.md
# Debug Byte Access Sequencer

This block sequences a debug host through the bytes of a multi-byte word held in a small memory. The host raises a read command or a write command and holds it for the whole access. The sequencer answers each such handshake with a registered read enable and a registered write enable. It also keeps a byte index that selects the byte within the word.

When the host drops its command, the sequencer moves the index on by one. The index runs 1, 2, 3 and then returns to 1. On that return the sequencer gives a one-cycle, active-low pulse that tells an external counter to step to the next word address. The memory, the address counter and the bus drivers are outside this block. One access is taken per handshake. Holding a command never advances the index a second time.

Top module: `dbs_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_en` and `wr_en` are 0, `addr_inc_n` is 1 and `byte_idx` is 1.
- R2: When the sequencer is idle and a clock edge samples `rd_cmd` or `wr_cmd` high, then from the next cycle `rd_en` equals `rd_cmd` and `wr_en` equals `wr_cmd`, as sampled at that edge. No enable rises without a command at the previous edge.
- R3: After that first edge, and for as long as either command stays high, `rd_en` follows `rd_cmd` with one cycle of lag and `wr_en` is 0.
- R4: At the first edge where both commands are low after an access, the index increments from 1 to 2 or from 2 to 3. Both enables drop at that same edge, and the new values are visible in the next cycle.
- R5: At the release edge of an access, an index of 3 becomes 1, and `addr_inc_n` is 0 for exactly that one following cycle. `addr_inc_n` is 1 in every other cycle.
- R6: `byte_idx` changes only at a release edge. It stays unchanged while idle and while a command is held, however long the command is held.
- R7: If both commands are high at the start of an access, then both enables are 1 in the first cycle. From then on only `wr_en` is 0 and `rd_en` follows `rd_cmd`. The bench reports this case as a host protocol error, not as a failure.
- R8: After a release, a command raised at the very next edge starts a new access. The index then advances once per handshake across any number of consecutive accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | Host read command, held high for one access |
| wr_cmd | input | 1 | Host write command, held high for one access |
| rd_en | output | 1 | Registered byte read enable, active high |
| wr_en | output | 1 | Registered byte write enable, active high |
| addr_inc_n | output | 1 | Registered word-address increment strobe, active low |
| byte_idx | output | IDX_W | Current byte index within the word |

## Verification
The hardest situations to reach are the wrap pulse and the back-to-back restart. Both need an exact history of handshakes. The address pulse appears only on every third release, and a restart needs a command raised in the cycle right after a release edge. The bench keeps its own index model and drives long runs of accesses with mixed reads and writes and hold times from zero to several cycles. Some accesses restart with no idle cycle in between, and one changes from read to write partway through a hold. Across these runs every wrap lands at a different point.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_SPARE2 = 2'd2,
    ST_SPARE3 = 2'd3
  } dbs_state_t;
endpackage

// File: rtl/dbs_index_reg.sv
module dbs_index_reg #(
  parameter int IDX_W     = 3,
  parameter int IDX_FIRST = 1,
  parameter int IDX_LAST  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);
  localparam logic [IDX_W-1:0] FIRST_V = IDX_W'(IDX_FIRST);
  localparam logic [IDX_W-1:0] LAST_V  = IDX_W'(IDX_LAST);
  localparam logic [IDX_W-1:0] MAX_V   = IDX_W'((1 << IDX_W) - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  assign at_last = (idx_q == LAST_V);

  always_comb begin
    idx_d = idx_q;
    if (step) begin
      if (at_last)
        idx_d = FIRST_V;
      else if (idx_q < MAX_V)
        idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= FIRST_V;
    else     idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_cmd,
  input  logic       wr_cmd,
  input  logic       at_last,
  output logic       step,
  output dbs_state_t state,
  output logic       rd_en,
  output logic       wr_en,
  output logic       addr_inc_n
);
  dbs_state_t st_q, st_d;
  logic rd_d, wr_d, inc_n_d;
  logic any_cmd;

  assign any_cmd = rd_cmd | wr_cmd;

  always_comb begin
    st_d    = st_q;
    rd_d    = 1'b0;
    wr_d    = 1'b0;
    inc_n_d = 1'b1;
    step    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (any_cmd) begin
          rd_d = rd_cmd;
          wr_d = wr_cmd;
          st_d = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (any_cmd) begin
          rd_d = rd_cmd;
        end else begin
          step    = 1'b1;
          inc_n_d = ~at_last;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      rd_en      <= 1'b0;
      wr_en      <= 1'b0;
      addr_inc_n <= 1'b1;
    end else begin
      st_q       <= st_d;
      rd_en      <= rd_d;
      wr_en      <= wr_d;
      addr_inc_n <= inc_n_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
  import dbs_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int IDX_FIRST = 1,
  parameter int IDX_LAST  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_cmd,
  input  logic             wr_cmd,
  output logic             rd_en,
  output logic             wr_en,
  output logic             addr_inc_n,
  output logic [IDX_W-1:0] byte_idx
);
  logic       step;
  logic       at_last;
  dbs_state_t seq_state;

  dbs_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rd_cmd     (rd_cmd),
    .wr_cmd     (wr_cmd),
    .at_last    (at_last),
    .step       (step),
    .state      (seq_state),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .addr_inc_n (addr_inc_n)
  );

  dbs_index_reg #(
    .IDX_W     (IDX_W),
    .IDX_FIRST (IDX_FIRST),
    .IDX_LAST  (IDX_LAST)
  ) u_idx (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .idx     (byte_idx),
    .at_last (at_last)
  );
endmodule

// File: rtl/dbs_sequencer_chk.sv
module dbs_sequencer_chk
  import dbs_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int IDX_FIRST = 1,
  parameter int IDX_LAST  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_cmd,
  input logic             wr_cmd,
  input logic             rd_en,
  input logic             wr_en,
  input logic             addr_inc_n,
  input logic [IDX_W-1:0] byte_idx,
  input dbs_state_t       seq_state
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: values left by a reset edge
  always_ff @(posedge clk) begin
    if (rst_seen)
      a_r1_reset_values: assert (!rd_en && !wr_en && addr_inc_n &&
                                 byte_idx == IDX_W'(IDX_FIRST));
  end

  a_r2_rd_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> $past(rd_cmd));

  a_r2_wr_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> $past(wr_cmd));

  a_r3_no_write_in_hold: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_BUSY && $past(seq_state == ST_BUSY)) |-> !wr_en);

  a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !addr_inc_n |=> addr_inc_n);

  a_r5_pulse_on_wrap: assert property (@(posedge clk) disable iff (rst)
    $fell(addr_inc_n) |-> (byte_idx == IDX_W'(IDX_FIRST) &&
                           $past(byte_idx) == IDX_W'(IDX_LAST)));

  a_r6_idx_moves_on_release: assert property (@(posedge clk) disable iff (rst)
    (byte_idx != $past(byte_idx)) |->
      $past(seq_state == ST_BUSY && !rd_cmd && !wr_cmd));
endmodule

bind dbs_sequencer dbs_sequencer_chk #(
  .IDX_W     (IDX_W),
  .IDX_FIRST (IDX_FIRST),
  .IDX_LAST  (IDX_LAST)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_cmd     (rd_cmd),
  .wr_cmd     (wr_cmd),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .addr_inc_n (addr_inc_n),
  .byte_idx   (byte_idx),
  .seq_state  (seq_state)
);

// File: tb/tb_dbs_sequencer.sv
`timescale 1ns/1ps
module tb_dbs_sequencer;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_cmd = 1'b0;
  logic wr_cmd = 1'b0;
  logic rd_en, wr_en, addr_inc_n;
  logic [IDX_W-1:0] byte_idx;

  int n_cmp = 0;
  int n_bad = 0;
  int model_idx = 1;
  int wrap_pulses = 0;

  always #2 clk = ~clk;

  dbs_sequencer #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .rd_en(rd_en), .wr_en(wr_en), .addr_inc_n(addr_inc_n),
    .byte_idx(byte_idx)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One handshake: raise command, hold extra cycles, release.
  task automatic do_access(input logic rd, input logic wr, input int hold, input bit restart_next);
    int exp_idx;
    bit exp_wrap;
    if (rd && wr) $display("NOTE host protocol error: read and write raised together (R7)");
    rd_cmd = rd; wr_cmd = wr;
    tick();
    chk("R2", "rd_en first", rd_en, rd);
    chk("R2", "wr_en first", wr_en, wr);
    chk("R6", "idx at start", byte_idx, model_idx);
    for (int k = 0; k < hold; k++) begin
      tick();
      chk("R3", "rd_en hold", rd_en, rd);
      chk("R3", "wr_en hold", wr_en, 0);
      chk("R6", "idx hold", byte_idx, model_idx);
      chk("R5", "inc_n hold", addr_inc_n, 1);
    end
    rd_cmd = 1'b0; wr_cmd = 1'b0;
    exp_wrap = (model_idx == 3);
    exp_idx  = exp_wrap ? 1 : model_idx + 1;
    tick();
    chk("R4", "idx after release", byte_idx, exp_idx);
    chk("R4", "rd_en after release", rd_en, 0);
    chk("R4", "wr_en after release", wr_en, 0);
    chk("R5", "inc_n after release", addr_inc_n, exp_wrap ? 0 : 1);
    if (!addr_inc_n) wrap_pulses++;
    model_idx = exp_idx;
    if (!restart_next) begin
      tick();
      chk("R5", "inc_n one cycle", addr_inc_n, 1);
      chk("R6", "idx idle", byte_idx, model_idx);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    chk("R1", "rd_en in reset", rd_en, 0);
    chk("R1", "wr_en in reset", wr_en, 0);
    chk("R1", "inc_n in reset", addr_inc_n, 1);
    chk("R1", "idx in reset", byte_idx, 1);
    rst = 1'b0;
    tick();
    chk("R1", "idx after reset", byte_idx, 1);
    chk("R1", "rd_en after reset", rd_en, 0);
    model_idx = 1;
  endtask

  task automatic t_basic_wrap();
    wrap_pulses = 0;
    do_access(1'b1, 1'b0, 2, 1'b0);
    do_access(1'b0, 1'b1, 1, 1'b0);
    do_access(1'b1, 1'b0, 0, 1'b0);
    chk("R5", "wrap count first word", wrap_pulses, 1);
  endtask

  task automatic t_long_hold_idle();
    do_access(1'b0, 1'b1, 20, 1'b0);
    for (int k = 0; k < 5; k++) tick();
    chk("R6", "idx long idle", byte_idx, model_idx);
    chk("R5", "inc_n long idle", addr_inc_n, 1);
  endtask

  task automatic t_both_cmds();
    do_access(1'b1, 1'b1, 2, 1'b0);
  endtask

  task automatic t_switch_in_hold();
    rd_cmd = 1'b1; wr_cmd = 1'b0;
    tick();
    chk("R2", "rd_en switch start", rd_en, 1);
    rd_cmd = 1'b0; wr_cmd = 1'b1;
    tick();
    chk("R3", "rd_en after switch", rd_en, 0);
    chk("R3", "wr_en after switch", wr_en, 0);
    chk("R6", "idx after switch", byte_idx, model_idx);
    wr_cmd = 1'b0;
    tick();
    model_idx = (model_idx == 3) ? 1 : model_idx + 1;
    chk("R4", "idx after switched access", byte_idx, model_idx);
    tick();
  endtask

  task automatic t_back_to_back();
    wrap_pulses = 0;
    for (int n = 0; n < 9; n++)
      do_access(n[0], ~n[0], n % 3, (n != 8));
    tick();
    chk("R8", "wraps in 9 accesses", wrap_pulses, 3);
    chk("R8", "idx after 9 accesses", byte_idx, model_idx);
  endtask

  initial begin
    #20000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic_wrap();
    t_long_hold_idle();
    t_both_cmds();
    t_switch_in_hold();
    t_back_to_back();
    t_reset();
    do_access(1'b1, 1'b0, 1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule